// File: doc/BRIEF.md
# Flash byte-program pulse sequencer

This block sits on the host side of a parallel flash device that takes commands through a register. It programs single bytes with a pulse-and-verify loop. A byte request arrives as an address and a data value on a valid/ready handshake. Each attempt then runs in a fixed order. First a set-up command (40h) is written. Next comes a write carrying the target address and data, which starts a program pulse, and the sequencer waits out the pulse time. A verify command (C0h) ends the pulse, and the sequencer waits a recovery time. Last, it reads the byte back and compares it with the requested data.

A mismatch starts another attempt. When the attempt budget is used up, the byte is declared failed. After a byte flagged as the last of a batch, or after any failure, the sequencer writes 00h to put the device back in read mode. It then posts a one-cycle result: pass or fail, the number of pulses used, and the byte's address. All device accesses go out as single read or write requests to a bus-timing engine. Each request is held until that engine signals completion. Bytes may be given in any address order, and the pulse count starts again for every byte.

Top module: `flash_pgm_seq`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and res_valid is 0, including when reset is applied in the middle of a byte.
- R2: Every attempt issues four bus accesses in this order: a write of 40h to the target address, a write of the request data to the target address, a write of C0h, and a read (bus_we=0) of the target address.
- R3: At least PULSE_CYC clock cycles pass between completion of the data write and the first cycle on which the C0h write is requested.
- R4: At least RECOV_CYC clock cycles pass between completion of the C0h write and the first cycle on which the read-back is requested.
- R5: When the read-back equals the request data, the block raises res_valid for exactly one cycle with res_ok=1 and res_pulses equal to the number of data writes made for that byte.
- R6: On a mismatch the attempt is repeated. After MAX_PULSES mismatching attempts, no further data write is made, and the result carries res_ok=0, res_pulses=MAX_PULSES and res_addr equal to the failing address.
- R7: A write of 00h is issued before the result when the byte was flagged by req_last or has failed. It is not issued after a byte that passed without the flag.
- R8: req_ready is 1 only while the block is idle (no bus request and no result pending). The pulse count restarts from zero for each accepted request.
- R9: Once bus_valid rises, it stays high with bus_we, bus_addr and bus_wdata unchanged until the cycle in which bus_done is 1.
- R10: Requests are handled in whatever address order they arrive, and res_addr always reports the address of the request just finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Byte request valid |
| req_ready | output | 1 | Byte request accepted when high together with req_valid |
| req_addr | input | AW | Target byte address |
| req_data | input | DW | Byte value to program |
| req_last | input | 1 | Request is the final byte of a batch; return device to read mode afterwards |
| bus_valid | output | 1 | Bus access requested |
| bus_we | output | 1 | 1 for a write access, 0 for a read access |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data or command code |
| bus_done | input | 1 | Bus-timing engine completed the current access |
| bus_rdata | input | DW | Read data, valid with bus_done on a read |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | 1 when the byte verified |
| res_pulses | output | $clog2(MAX_PULSES+1) | Program pulses used for the byte |
| res_addr | output | AW | Address of the finished byte |

## Verification
The bench builds the block with MAX_PULSES=4, PULSE_CYC=20, RECOV_CYC=6 and an 8-bit address. The small pulse cap makes the give-up path reachable within a few attempts. It also lets a following byte show that the count restarts. The short pulse and recovery windows keep each byte near a hundred cycles, yet they stay long enough that measuring the gaps separates a correct wait from a shortened one. A bus model that needs a chosen number of pulses before it reads back the true value drives passes on the first, middle and final allowed attempt, as well as a failure one attempt past the cap.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

   // Command codes written to the flash command register
   localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
   localparam logic [7:0] CMD_VERIFY    = 8'hC0;
   localparam logic [7:0] CMD_READ_MODE = 8'h00;

   typedef enum logic [3:0] {
      S_IDLE,
      S_SETUP,
      S_PROG,
      S_PWAIT,
      S_VERIFY,
      S_RWAIT,
      S_READ,
      S_RDMODE,
      S_REPORT
   } fpgm_state_e;

endpackage

// File: rtl/fpgm_wait_timer.sv
module fpgm_wait_timer #(
   parameter int WAIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);

   if (WAIT < 0) begin : g_bad_wait
      $error("fpgm_wait_timer: WAIT must be non-negative");
   end

   if (WAIT <= 1) begin : g_flag
      // Short wait: a single busy flag covers it
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= start;
      end
      assign expired = !busy_q;
   end else begin : g_count
      localparam int CW = $clog2(WAIT + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (start)          cnt_q <= CW'(WAIT);
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign expired = (cnt_q == '0);
   end

   // A started wait is never already over on the next cycle (R3, R4)
   assert_start_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !expired);

endmodule

// File: rtl/fpgm_attempt_ctr.sv
module fpgm_attempt_ctr #(
   parameter int MAX = 25,
   localparam int CW = $clog2(MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          inc,
   output logic [CW-1:0] cnt,
   output logic          at_max
);

   if (MAX < 1) begin : g_bad_max
      $error("fpgm_attempt_ctr: MAX must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (inc)   cnt_q <= cnt_q + 1'b1;
   end

   assign cnt    = cnt_q;
   assign at_max = (cnt_q == CW'(MAX));

   // No pulse is counted once the budget is spent (R6)
   assert_no_pulse_past_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !at_max);

   // A fresh request always starts from zero (R8)
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !inc) |=> (cnt == '0));

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
   import fpgm_pkg::*;
#(
   parameter int AW         = 17,
   parameter int DW         = 8,
   parameter int PULSE_CYC  = 1000,
   parameter int RECOV_CYC  = 600,
   parameter int MAX_PULSES = 25
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic [AW-1:0]                   req_addr,
   input  logic [DW-1:0]                   req_data,
   input  logic                            req_last,
   output logic                            bus_valid,
   output logic                            bus_we,
   output logic [AW-1:0]                   bus_addr,
   output logic [DW-1:0]                   bus_wdata,
   input  logic                            bus_done,
   input  logic [DW-1:0]                   bus_rdata,
   output logic                            res_valid,
   output logic                            res_ok,
   output logic [$clog2(MAX_PULSES+1)-1:0] res_pulses,
   output logic [AW-1:0]                   res_addr
);

   localparam int PCW    = $clog2(MAX_PULSES + 1);
   localparam int GAPMAX = ((PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC) + 1;
   localparam int GW     = $clog2(GAPMAX + 1);

   if (AW < 1 || DW < 8 || MAX_PULSES < 1 || PULSE_CYC < 0 || RECOV_CYC < 0) begin : g_bad_param
      $error("flash_pgm_seq: parameter out of range");
   end

   fpgm_state_e st_q, st_d;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          last_q;
   logic          ok_q;

   logic accept;
   logic pulse_start, pulse_over;
   logic recov_start, recov_over;
   logic cnt_clear, cnt_inc, cnt_at_max;
   logic [PCW-1:0] cnt;
   logic match;

   assign req_ready = (st_q == S_IDLE);
   assign accept    = req_valid && req_ready;

   assign pulse_start = (st_q == S_PROG)   && bus_done;
   assign recov_start = (st_q == S_VERIFY) && bus_done;
   assign cnt_clear   = accept;
   assign cnt_inc     = pulse_start;
   assign match       = (bus_rdata == data_q);

   fpgm_wait_timer #(.WAIT(PULSE_CYC)) pulse_tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (pulse_start),
      .expired (pulse_over)
   );

   fpgm_wait_timer #(.WAIT(RECOV_CYC)) recov_tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (recov_start),
      .expired (recov_over)
   );

   fpgm_attempt_ctr #(.MAX(MAX_PULSES)) attempt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cnt_clear),
      .inc    (cnt_inc),
      .cnt    (cnt),
      .at_max (cnt_at_max)
   );

   // Sequencing
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:   if (accept)     st_d = S_SETUP;
         S_SETUP:  if (bus_done)   st_d = S_PROG;
         S_PROG:   if (bus_done)   st_d = S_PWAIT;
         S_PWAIT:  if (pulse_over) st_d = S_VERIFY;
         S_VERIFY: if (bus_done)   st_d = S_RWAIT;
         S_RWAIT:  if (recov_over) st_d = S_READ;
         S_READ: begin
            if (bus_done) begin
               if (match)           st_d = last_q ? S_RDMODE : S_REPORT;
               else if (cnt_at_max) st_d = S_RDMODE;
               else                 st_d = S_SETUP;
            end
         end
         S_RDMODE: if (bus_done)   st_d = S_REPORT;
         S_REPORT:                 st_d = S_IDLE;
         default:                  st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         addr_q <= '0;
         data_q <= '0;
         last_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            last_q <= req_last;
            ok_q   <= 1'b0;
         end else if (st_q == S_READ && bus_done) begin
            ok_q <= match;
         end
      end
   end

   // Bus request fields decoded from the state
   always_comb begin
      bus_valid = 1'b0;
      bus_we    = 1'b1;
      bus_addr  = addr_q;
      bus_wdata = '0;
      unique case (st_q)
         S_SETUP:  begin bus_valid = 1'b1; bus_wdata = DW'(CMD_PGM_SETUP); end
         S_PROG:   begin bus_valid = 1'b1; bus_wdata = data_q;             end
         S_VERIFY: begin bus_valid = 1'b1; bus_wdata = DW'(CMD_VERIFY);    end
         S_READ:   begin bus_valid = 1'b1; bus_we    = 1'b0;               end
         S_RDMODE: begin bus_valid = 1'b1; bus_wdata = DW'(CMD_READ_MODE); end
         default:  ;
      endcase
   end

   assign res_valid  = (st_q == S_REPORT);
   assign res_ok     = ok_q;
   assign res_pulses = cnt;
   assign res_addr   = addr_q;

   // Checker state: cycles since the last completed bus access
   logic [GW-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   gap_q <= '0;
      else if (bus_done)            gap_q <= '0;
      else if (gap_q != GW'(GAPMAX)) gap_q <= gap_q + 1'b1;
   end

   assert_pulse_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_valid) && bus_we && bus_wdata == DW'(CMD_VERIFY)) |-> (gap_q >= GW'(PULSE_CYC)));

   assert_recov_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_valid) && !bus_we) |-> (gap_q >= GW'(RECOV_CYC)));

   assert_result_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_fail_readmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ok) |->
         $past(bus_done && bus_valid && bus_we && bus_wdata == DW'(CMD_READ_MODE)));

   assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_valid && !res_valid));

   assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_done) |=>
         (bus_valid && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: tb/flash_pgm_seq_tb_top.sv
module flash_pgm_seq_tb_top;

   localparam int AW    = 8;
   localparam int DW    = 8;
   localparam int PULSE = 20;
   localparam int RECOV = 6;
   localparam int MAXP  = 4;
   localparam int PCW   = $clog2(MAXP + 1);

   // Vector: addr[25:18] data[17:10] last[9] need[8:5] ok[4] pulses[3:0]
   localparam int NV = 6;
   localparam logic [25:0] VEC [NV] = '{
      {8'h10, 8'hA5, 1'b0, 4'd1, 1'b1, 4'd1},
      {8'h03, 8'h3C, 1'b0, 4'd3, 1'b1, 4'd3},
      {8'hF0, 8'h00, 1'b1, 4'd4, 1'b1, 4'd4},
      {8'h7E, 8'h5A, 1'b0, 4'd5, 1'b0, 4'd4},
      {8'h7F, 8'h81, 1'b0, 4'd2, 1'b1, 4'd2},
      {8'h01, 8'h42, 1'b1, 4'd1, 1'b1, 4'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic req_last = 1'b0;
   logic bus_valid, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic bus_done = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic res_valid, res_ok;
   logic [PCW-1:0] res_pulses;
   logic [AW-1:0] res_addr;

   always #5 clk = ~clk;

   flash_pgm_seq #(
      .AW(AW), .DW(DW), .PULSE_CYC(PULSE), .RECOV_CYC(RECOV), .MAX_PULSES(MAXP)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
      .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
      .res_valid(res_valid), .res_ok(res_ok), .res_pulses(res_pulses),
      .res_addr(res_addr)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   task automatic chk(input bit cond, input string what, input int act, input int exp);
      n_checks++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // Flash model behind the bus-timing engine
   int phase = 0;
   int pcount = 0;
   int need = 1;
   int rdmode_cnt = 0;
   int lat = 0;
   int t_done = 0;
   logic [AW-1:0] tgt_a = '0;
   logic [DW-1:0] tgt_d = '0;
   logic [AW-1:0] seen_a;
   logic [DW-1:0] seen_d;
   logic seen_we;

   task automatic serve();
      chk(bus_addr == seen_a && bus_wdata == seen_d && bus_we == seen_we,
          "R9 request held until done", int'(bus_wdata), int'(seen_d));
      if (phase == 0 && bus_we && bus_wdata == 8'h00) begin
         rdmode_cnt++;
      end else begin
         case (phase)
            0: begin
               chk(bus_we && bus_wdata == 8'h40 && bus_addr == tgt_a,
                   "R2 set-up write", int'(bus_wdata), 'h40);
               phase = 1;
            end
            1: begin
               chk(bus_we && bus_addr == tgt_a && bus_wdata == tgt_d,
                   "R2 data write", int'(bus_wdata), int'(tgt_d));
               pcount++;
               phase = 2;
            end
            2: begin
               chk(bus_we && bus_wdata == 8'hC0, "R2 verify write", int'(bus_wdata), 'hC0);
               phase = 3;
            end
            default: begin
               chk(!bus_we && bus_addr == tgt_a, "R2 read-back", int'(bus_addr), int'(tgt_a));
               bus_rdata = (pcount >= need) ? tgt_d : 8'hFF;
               phase = 0;
            end
         endcase
      end
      t_done = cyc;
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         bus_done = 1'b0;
         lat = 0;
      end else if (bus_done) begin
         bus_done = 1'b0;
      end else if (bus_valid) begin
         if (lat == 0) begin
            seen_a = bus_addr; seen_d = bus_wdata; seen_we = bus_we;
            if (phase == 2)
               chk(cyc - t_done >= PULSE, "R3 pulse length", cyc - t_done, PULSE);
            if (phase == 3)
               chk(cyc - t_done >= RECOV, "R4 recovery time", cyc - t_done, RECOV);
         end
         if (lat < 1) lat++;
         else begin
            lat = 0;
            bus_done = 1'b1;
            serve();
         end
      end
   end

   task automatic run_vec(input int i);
      logic [25:0] v;
      int rd0, k;
      bit exp_ok, lst;
      int exp_p;
      v = VEC[i];
      tgt_a = v[25:18]; tgt_d = v[17:10]; lst = v[9];
      need = int'(v[8:5]); exp_ok = v[4]; exp_p = int'(v[3:0]);
      pcount = 0; phase = 0; rd0 = rdmode_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_addr = tgt_a; req_data = tgt_d; req_last = lst;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (i == 0) chk(!req_ready, "R8 ready low while busy", int'(req_ready), 0);
      k = 0;
      while (!res_valid && k < 5000) begin @(negedge clk); k++; end
      chk(res_valid, "R5 result strobe", int'(res_valid), 1);
      chk(res_ok == exp_ok, exp_ok ? "R5 pass reported" : "R6 failure reported",
          int'(res_ok), int'(exp_ok));
      chk(int'(res_pulses) == exp_p, exp_ok ? "R5 pulse count" : "R6 pulse count at cap",
          int'(res_pulses), exp_p);
      chk(pcount == exp_p, "R6 data writes made", pcount, exp_p);
      chk(res_addr == tgt_a, "R10 result address", int'(res_addr), int'(tgt_a));
      chk(rdmode_cnt - rd0 == ((lst || !exp_ok) ? 1 : 0), "R7 read-mode write",
          rdmode_cnt - rd0, (lst || !exp_ok) ? 1 : 0);
      @(negedge clk);
      chk(!res_valid, "R5 result one cycle", int'(res_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && !bus_valid && !res_valid, "R1 reset state",
          int'({req_ready, bus_valid, res_valid}), 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !bus_valid, "R1 idle after reset",
          int'({req_ready, bus_valid}), 2);

      for (int i = 0; i < NV; i++) run_vec(i);

      // Reset in the middle of a pulse wait
      tgt_a = 8'h55; tgt_d = 8'h12; need = 1; pcount = 0; phase = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = tgt_a; req_data = tgt_d; req_last = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (12) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(req_ready && !bus_valid && !res_valid, "R1 reset mid-byte",
          int'({req_ready, bus_valid, res_valid}), 4);
      phase = 0;
      rst_n = 1'b1;
      run_vec(4);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule